// File: doc/BRIEF.md
# Playfield Mode Decoder

This block turns the 3-bit playfield code that arrives once per colour clock into the timing strobes of a video line and into an 8-bit colour/luminance value. Code values below 4 carry control meaning: background, vertical sync, or horizontal blank. A horizontal blank code also sets or clears a 40-character mode flag. A 2-bit mode input picks how codes with bit 2 set are read. In normal mode they select one of four playfield colour registers directly.

In the three extended modes a pixel lasts two colour clocks. Each clock carries 2 data bits, and the block joins them into a 4-bit pixel value. That value then does one of three things. It is ORed into the luminance of the background register, or it is ORed into the hue of the background register, or it picks one of the nine colour registers. The colour registers enter as one flat bus. Slot 0..3 holds the player colours, slot 4..7 the playfield colours and slot 8 the background. Within each byte, bits 7:4 are the hue and bits 3:0 the luminance.

Top module: `pf_mode_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is driven to 0 after that edge, including the 40-character flag.
- R2: The outputs follow the code one clock later. Code 001 raises `vsync`, codes 010 and 011 raise `hblank`, and for any of these three codes `colour_out` is 0.
- R3: Code 011 sets `wide_mode` and code 010 clears it, one clock later. Every other code leaves `wide_mode` unchanged.
- R4: With `pf_mode` = 00 (normal), code 000 gives the background slot 8 and code 1xx gives playfield slot 4+xx. The value appears one clock after the code.
- R5: `pf_mode` encodes 00 normal, 01 sixteen luminances, 10 nine colour registers and 11 sixteen hues. The mode is applied at the clock edge where the colour output is registered.
- R6: In the extended modes, a pixel phase alternates every clock and is forced back to the first half by each horizontal blank code. The first-half code supplies value bits 3:2 and the second-half code supplies bits 1:0. The joined value is shown on `colour_out` for the two clocks that follow the clock after the second half.
- R7: In mode 01, a playfield pixel outputs the background hue (bits 7:4) with luminance equal to background bits 3:0 ORed with the pixel value.
- R8: In mode 11, a playfield pixel outputs the background luminance (bits 3:0) with hue equal to background bits 7:4 ORed with the pixel value.
- R9: In mode 10, pixel values 0000..0011 select player slots 0..3, values x100..x111 select playfield slots 4..7, and values 10xx select background slot 8.
- R10: In the extended modes, a pixel in which neither half carried bit 2 set outputs the background slot 8 unchanged. A horizontal blank code also discards the pixel being built, leaving the background to be shown until the next pair completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Colour clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_code | input | 3 | Playfield code for this colour clock |
| pf_mode | input | 2 | Playfield interpretation mode |
| colour_regs | input | 72 | Nine colour registers, slot n at bits 8n+7:8n |
| vsync | output | 1 | Vertical sync strobe |
| hblank | output | 1 | Horizontal blank strobe |
| wide_mode | output | 1 | 40-character mode flag |
| colour_out | output | 8 | Selected colour (hue 7:4, luminance 3:0) |

## Verification
Normal mode is driven with the four playfield codes and the background code mixed at random. This separates slot indexing from the latency check. Random streams that include sync and both blank codes are used to separate the `vsync` and `hblank` decode, and to show that the wide flag holds between blank codes. Each extended mode gets its own lines of random data codes with occasional non-playfield codes. This covers every OR path and the background fallback. A sweep of all sixteen values in the nine-register mode, together with blank codes placed in the middle of a pixel, tells apart a wrong pairing order from a phase that fails to restart at the start of a line.

// File: rtl/pfd_pkg.sv
// Shared constants and types for the playfield mode decoder.
// Assumes a 3-bit playfield code and a 4-bit extended pixel value.
package pfd_pkg;

    localparam int CODE_W  = 3;
    localparam int HALF_W  = 2;
    localparam int PIX_W   = 2 * HALF_W;
    localparam int NUM_PM  = 4;
    localparam int NUM_PF  = 4;
    localparam int NREG    = NUM_PM + NUM_PF + 1;
    localparam int IDX_W   = $clog2(NREG);
    localparam int SLOT_PM0 = 0;
    localparam int SLOT_PF0 = NUM_PM;
    localparam int SLOT_BG  = NUM_PM + NUM_PF;

    localparam logic [CODE_W-1:0] CODE_BG    = 3'b000;
    localparam logic [CODE_W-1:0] CODE_VSYNC = 3'b001;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_LUM16  = 2'b01,
        MODE_NINE   = 2'b10,
        MODE_HUE16  = 2'b11
    } pf_mode_e;

    typedef struct packed {
        logic             is_pf;
        logic [PIX_W-1:0] val;
    } pix_t;

endpackage

// File: rtl/pfd_code_ctrl.sv
// Control-code decode: vertical sync, horizontal blank and the 40-character
// flag. Assumes the code is stable around the clock edge; outputs lag by one clock.
module pfd_code_ctrl
    import pfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] pf_code,
    output logic              hbl_code,
    output logic              blank_code,
    output logic              vsync,
    output logic              hblank,
    output logic              wide_mode
);

    logic vs_code;

    // Classify the current code as sync or blank.
    always_comb begin
        vs_code    = (pf_code == CODE_VSYNC);
        hbl_code   = (pf_code[2:1] == 2'b01);
        blank_code = vs_code | hbl_code;
    end

    // Register the strobes one clock after their code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsync  <= 1'b0;
            hblank <= 1'b0;
        end else begin
            vsync  <= vs_code;
            hblank <= hbl_code;
        end
    end

    // The 40-character flag follows bit 0 of each blank code and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_mode <= 1'b0;
        end else if (hbl_code) begin
            wide_mode <= pf_code[0];
        end
    end

endmodule

// File: rtl/pfd_pixel_pack.sv
// Joins two 2-bit data transfers into one extended pixel value.
// Assumes horizontal blank marks the start of a line; the phase restarts there.
module pfd_pixel_pack
    import pfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] pf_code,
    input  logic              hbl_code,
    output logic              phase,
    output pix_t              pixel
);

    logic              half_pf;
    logic [HALF_W-1:0] half_data;
    logic [HALF_W-1:0] hi_q;
    logic              hi_pf_q;

    // Data bits carried by this code; non-playfield codes contribute zeros.
    always_comb begin
        half_pf   = pf_code[CODE_W-1];
        half_data = half_pf ? pf_code[HALF_W-1:0] : '0;
    end

    // Pixel phase: alternate every clock, restart on horizontal blank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
        end else if (hbl_code) begin
            phase <= 1'b0;
        end else begin
            phase <= ~phase;
        end
    end

    // Hold the upper half captured in the first phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            hi_pf_q <= 1'b0;
        end else if (!hbl_code && !phase) begin
            hi_q    <= half_data;
            hi_pf_q <= half_pf;
        end
    end

    // Complete the pixel in the second phase; blank discards it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pixel <= '0;
        end else if (hbl_code) begin
            pixel <= '0;
        end else if (phase) begin
            pixel.is_pf <= hi_pf_q | half_pf;
            pixel.val   <= {hi_q, half_data};
        end
    end

endmodule

// File: rtl/pfd_colour_sel.sv
// Picks the output colour from the nine colour slots according to the mode.
// Assumes hue in the upper LUM_W-complement bits and luminance in the low LUM_W bits.
module pfd_colour_sel
    import pfd_pkg::*;
#(
    parameter int CW    = 8,
    parameter int LUM_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  pf_code,
    input  logic               blank_code,
    input  pf_mode_e           mode,
    input  pix_t               pixel,
    input  logic [NREG*CW-1:0] colour_regs,
    output logic [CW-1:0]      colour_out
);

    localparam int HUE_W = CW - LUM_W;

    logic [CW-1:0]    slot [NREG];
    logic [IDX_W-1:0] sel_idx;
    logic             use_lum_mix;
    logic             use_hue_mix;
    logic [CW-1:0]    bg;
    logic [CW-1:0]    mixed;
    logic [CW-1:0]    colour_nxt;

    // Split the flat register bus into slots.
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        assign slot[g] = colour_regs[g*CW +: CW];
    end

    // Choose the slot index or a mix path for the current mode.
    always_comb begin
        sel_idx     = IDX_W'(SLOT_BG);
        use_lum_mix = 1'b0;
        use_hue_mix = 1'b0;
        unique case (mode)
            MODE_NORMAL: begin
                if (pf_code[CODE_W-1]) begin
                    sel_idx = IDX_W'(SLOT_PF0) + IDX_W'(pf_code[1:0]);
                end
            end
            MODE_NINE: begin
                if (pixel.is_pf) begin
                    if (pixel.val[2]) begin
                        sel_idx = IDX_W'(SLOT_PF0) + IDX_W'(pixel.val[1:0]);
                    end else if (!pixel.val[3]) begin
                        sel_idx = IDX_W'(SLOT_PM0) + IDX_W'(pixel.val[1:0]);
                    end
                end
            end
            MODE_LUM16: use_lum_mix = pixel.is_pf;
            MODE_HUE16: use_hue_mix = pixel.is_pf;
        endcase
    end

    // Build the OR-mixed colour from the background slot.
    always_comb begin
        bg    = slot[SLOT_BG];
        mixed = bg;
        if (use_lum_mix) begin
            mixed[LUM_W-1:0] = bg[LUM_W-1:0] | LUM_W'(pixel.val);
        end
        if (use_hue_mix) begin
            mixed[CW-1:LUM_W] = bg[CW-1:LUM_W] | HUE_W'(pixel.val);
        end
    end

    // Final choice: black on sync or blank, mix or indexed slot otherwise.
    always_comb begin
        if (blank_code) begin
            colour_nxt = '0;
        end else if (use_lum_mix || use_hue_mix) begin
            colour_nxt = mixed;
        end else begin
            colour_nxt = slot[sel_idx];
        end
    end

    // Register the colour output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            colour_out <= '0;
        end else begin
            colour_out <= colour_nxt;
        end
    end

endmodule

// File: rtl/pf_mode_decoder.sv
// Top of the playfield mode decoder: control decode, pixel pairing and
// colour selection. Assumes one playfield code per colour clock.
module pf_mode_decoder
    import pfd_pkg::*;
#(
    parameter int CW    = 8,
    parameter int LUM_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 pf_code,
    input  logic [1:0]                 pf_mode,
    input  logic [pfd_pkg::NREG*CW-1:0] colour_regs,
    output logic                       vsync,
    output logic                       hblank,
    output logic                       wide_mode,
    output logic [CW-1:0]              colour_out
);

    logic     hbl_code;
    logic     blank_code;
    logic     pix_phase;
    pix_t     pixel;
    pf_mode_e mode;

    // Interpret the mode field.
    always_comb mode = pf_mode_e'(pf_mode);

    pfd_code_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pf_code    (pf_code),
        .hbl_code   (hbl_code),
        .blank_code (blank_code),
        .vsync      (vsync),
        .hblank     (hblank),
        .wide_mode  (wide_mode)
    );

    pfd_pixel_pack u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .pf_code  (pf_code),
        .hbl_code (hbl_code),
        .phase    (pix_phase),
        .pixel    (pixel)
    );

    pfd_colour_sel #(.CW(CW), .LUM_W(LUM_W)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .pf_code     (pf_code),
        .blank_code  (blank_code),
        .mode        (mode),
        .pixel       (pixel),
        .colour_regs (colour_regs),
        .colour_out  (colour_out)
    );

endmodule

// File: rtl/pf_mode_decoder_chk.sv
// Property checker for the playfield mode decoder, bound to the top.
module pf_mode_decoder_chk #(
    parameter int CW   = 8,
    parameter int NREG = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         pf_code,
    input logic [1:0]         pf_mode,
    input logic [NREG*CW-1:0] colour_regs,
    input logic               vsync,
    input logic               hblank,
    input logic               wide_mode,
    input logic [CW-1:0]      colour_out,
    input logic               pix_phase
);

    localparam int BG = NREG - 1;

    assert_vsync_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_code == 3'b001) |=> (vsync && !hblank && colour_out == '0));

    assert_hblank_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_code[2:1] == 2'b01) |=> (hblank && !vsync && colour_out == '0));

    assert_wide_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_code == 3'b011) |=> wide_mode);

    assert_wide_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_code == 3'b010) |=> !wide_mode);

    assert_wide_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_code[2:1] != 2'b01) |=> $stable(wide_mode));

    assert_normal_bg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_mode == 2'b00 && pf_code == 3'b000)
        |=> (colour_out == $past(colour_regs[BG*CW +: CW])));

    assert_phase_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hblank |-> !pix_phase);

    assert_phase_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_code[2:1] != 2'b01) |=> (pix_phase != $past(pix_phase)));

endmodule

bind pf_mode_decoder pf_mode_decoder_chk #(.CW(CW), .NREG(pfd_pkg::NREG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pf_code     (pf_code),
    .pf_mode     (pf_mode),
    .colour_regs (colour_regs),
    .vsync       (vsync),
    .hblank      (hblank),
    .wide_mode   (wide_mode),
    .colour_out  (colour_out),
    .pix_phase   (pix_phase)
);

// File: tb/pf_mode_decoder_tb_top.sv
`timescale 1ns/1ps
module pf_mode_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  pf_code = 3'b000;
    logic [1:0]  pf_mode = 2'b00;
    logic [71:0] colour_regs = '0;
    logic        vsync, hblank, wide_mode;
    logic [7:0]  colour_out;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 0;

    // Reference model state (behavioural)
    int m_phase = 0, m_hi = 0, m_hipf = 0, m_val = 0, m_pf = 0;
    int e_vs = 0, e_hb = 0, e_wide = 0, e_col = 0;

    always #2 clk = ~clk;

    pf_mode_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .pf_code(pf_code), .pf_mode(pf_mode),
        .colour_regs(colour_regs), .vsync(vsync), .hblank(hblank),
        .wide_mode(wide_mode), .colour_out(colour_out)
    );

    function automatic int slot(int i);
        return int'(colour_regs[i*8 +: 8]);
    endfunction

    // Reference model, advanced at every rising edge
    always @(posedge clk) begin
        int c, half, bg;
        c = int'(pf_code);
        if (!rst_n) begin
            m_phase = 0; m_hi = 0; m_hipf = 0; m_val = 0; m_pf = 0;
            e_vs = 0; e_hb = 0; e_wide = 0; e_col = 0;
        end else begin
            bg = slot(8);
            e_vs = (c == 1);
            e_hb = (c == 2 || c == 3);
            if (c == 3) e_wide = 1;
            if (c == 2) e_wide = 0;
            if (c >= 1 && c <= 3) e_col = 0;
            else if (pf_mode == 2'b00) e_col = (c == 0) ? bg : slot(4 + c % 4);
            else if (!m_pf) e_col = bg;
            else if (pf_mode == 2'b01) e_col = (bg & 8'hF0) | ((bg & 8'h0F) | m_val);
            else if (pf_mode == 2'b11) e_col = (((bg >> 4) | m_val) << 4) | (bg & 8'h0F);
            else if (m_val % 8 >= 4) e_col = slot(4 + m_val % 4);
            else if (m_val < 4) e_col = slot(m_val);
            else e_col = bg;
            half = (c >= 4) ? c % 4 : 0;
            if (c == 2 || c == 3) begin
                m_phase = 0; m_val = 0; m_pf = 0;
            end else if (m_phase == 0) begin
                m_hi = half; m_hipf = (c >= 4); m_phase = 1;
            end else begin
                m_val = m_hi * 4 + half; m_pf = m_hipf || (c >= 4); m_phase = 0;
            end
        end
    end

    task automatic compare();
        checks++;
        if (vsync !== e_vs[0] || hblank !== e_hb[0] || wide_mode !== e_wide[0]
            || colour_out !== e_col[7:0]) begin
            errors++;
            $display("FAIL %s: actual vs=%b hb=%b wide=%b col=%h expected vs=%0d hb=%0d wide=%0d col=%h",
                     cur_req, vsync, hblank, wide_mode, colour_out, e_vs, e_hb, e_wide, e_col[7:0]);
        end
    endtask

    // One cycle: check the result of the last edge, then drive the next code
    task automatic step(input logic [2:0] code);
        @(negedge clk);
        compare();
        pf_code = code;
    endtask

    task automatic load_regs();
        for (int i = 0; i < 9; i++) colour_regs[i*8 +: 8] = 8'($urandom);
    endtask

    task automatic ext_line(input int len, input int nonpf_pct);
        step(3'b010);
        for (int k = 0; k < len; k++) begin
            if (int'($urandom % 100) < nonpf_pct) step(3'b000);
            else step(3'(4 + $urandom % 4));
        end
    endtask

    initial begin
        load_regs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        compare();
        rst_n = 1'b1;

        // R4: normal mode playfield and background selection
        cur_req = "R4";
        pf_mode = 2'b00;
        for (int k = 0; k < 200; k++) begin
            int r = int'($urandom % 5);
            step(r == 0 ? 3'b000 : 3'(3 + r));
            if (k % 50 == 0) load_regs();
        end

        // R2 and R3: sync, blank and the 40-character flag
        cur_req = "R2";
        for (int k = 0; k < 300; k++) begin
            if (k == 150) cur_req = "R3";
            step(3'($urandom % 8));
        end

        // R7: sixteen luminances, background with low luminance
        cur_req = "R7";
        pf_mode = 2'b01;
        colour_regs[64 +: 8] = 8'hA0;
        for (int l = 0; l < 20; l++) ext_line(15, 10);
        colour_regs[64 +: 8] = 8'h35;
        for (int l = 0; l < 10; l++) ext_line(16, 10);

        // R8: sixteen hues
        cur_req = "R8";
        pf_mode = 2'b11;
        colour_regs[64 +: 8] = 8'h07;
        for (int l = 0; l < 20; l++) ext_line(16, 10);
        colour_regs[64 +: 8] = 8'h9C;
        for (int l = 0; l < 10; l++) ext_line(17, 10);

        // R9: nine registers, sweep every pixel value in order
        cur_req = "R9";
        pf_mode = 2'b10;
        load_regs();
        step(3'b011);
        for (int v = 0; v < 16; v++) begin
            step(3'(4 + v / 4));
            step(3'(4 + v % 4));
        end
        for (int l = 0; l < 20; l++) ext_line(20, 5);

        // R10: pixels with no playfield half show the background
        cur_req = "R10";
        for (int m = 1; m < 4; m++) begin
            pf_mode = 2'(m);
            for (int l = 0; l < 10; l++) ext_line(16, 60);
        end

        // R6: blank in the middle of a pixel, odd lengths, VSYNC in-line
        cur_req = "R6";
        for (int l = 0; l < 40; l++) begin
            pf_mode = 2'(1 + $urandom % 3);
            ext_line(int'(1 + $urandom % 9), 15);
            if (l % 4 == 0) step(3'b001);
        end

        // R5: mode switched while data keeps flowing
        cur_req = "R5";
        for (int k = 0; k < 300; k++) begin
            if (k % 7 == 0) pf_mode = 2'($urandom % 4);
            if (k % 37 == 0) step(3'b010);
            else step(3'($urandom % 8));
        end

        @(negedge clk);
        compare();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog %s: actual=running expected=finished", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule